// File: doc/BRIEF.md
# Sample-Rate-Paced Delta-Sigma DAC Peripheral

This block sits on a byte-wide I/O bus of a small processor and turns 8-bit samples into a one-bit pulse-density stream. It has two addresses. A write to the base address (`BASE_ADDR`, default `0xE0`) hands a new sample to a first-order delta-sigma modulator. A read from the address one above returns a status byte that tells software whether the modulator is ready for the next sample.

The modulator reproduces a sample's level correctly only when the duty cycle is averaged over a full 256-clock period. For this reason every accepted write starts an 8-bit busy timer. The timer starts from the rising edge of the write strobe, not from its level, so a strobe of any length starts exactly one period. While the timer runs, the acknowledge output and the ready bit are low. When the timer reaches its terminal count, the acknowledge returns high and a one-cycle completion pulse is raised.

Software polls the status address until it reads `0x01`, then writes the next sample. A requester that holds its strobe until it sees the acknowledge is paced at one sample per period.

Top module: `dac_periph`

## Requirements
- R1: A write is accepted only when `io_we` rises while `io_addr` equals `BASE_ADDR`. A strobe at any other address leaves the sample, the timer, `bus_ack` and `done_pulse` unchanged.
- R2: When `io_re` is high and `io_addr` equals `BASE_ADDR+1`, `io_rdata` is `0x01` while the peripheral is ready and `0x00` while it is busy.
- R3: `io_rdata` is `0x00` whenever `io_re` is low or `io_addr` is not `BASE_ADDR+1`. Reads change no state.
- R4: A write strobe held high for any number of cycles produces a single one-cycle start pulse, so it starts exactly one busy period.
- R5: The start pulse clears the 8-bit timer. The timer then increments once per clock and holds at 255.
- R6: `bus_ack` and the ready bit are both high exactly when the timer value is 255.
- R7: Let edge 0 be the first clock edge that samples an accepted strobe high. `bus_ack` is low after edges 1 through 255 and high again after edge 256. `done_pulse` is high only in the cycle that follows edge 256.
- R8: The sample register changes only on a start pulse. It then takes the value that `io_wdata` held at edge 0.
- R9: The modulator adds the sample to the low 8 bits of a 9-bit accumulator on every clock, and `dac_out` is the registered carry bit. Over any 256 consecutive cycles with a constant sample, `dac_out` is high for exactly as many cycles as the sample value.
- R10: `rst_n` is a synchronous, active-low reset. It sets the timer to 255, so the peripheral is ready, and clears the sample and the accumulator. While `rst_n` is low, `dac_out` and `done_pulse` are 0.
- R11: A write accepted while the peripheral is busy replaces the sample and restarts the full 256-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_addr | input | 8 | I/O address |
| io_wdata | input | 8 | Write data (sample) |
| io_we | input | 1 | Write strobe |
| io_re | input | 1 | Read strobe |
| io_rdata | output | 8 | Status read data |
| bus_ack | output | 1 | Transfer acknowledge, high when the timer is at its terminal count |
| done_pulse | output | 1 | One-cycle pulse when a sampling period ends |
| dac_out | output | 1 | One-bit pulse-density output |

## Verification
The assertions check on every cycle the local timer rules:
- the start pulse lasts one cycle and clears the timer;
- the timer counts up by one and then holds at 255;
- the sample stays stable between starts;
- the completion pulse appears only with the acknowledge;
- the read data is zero away from the status address.

Only the bench scenarios show the end-to-end behaviour:
- the exact 256-clock window measured from the strobe edge;
- a single period under a long strobe;
- the restart when a write arrives while busy;
- the pulse density over a full period, for the sample values 0, 255 and random values.

// File: rtl/dac_periph_pkg.sv
package dac_periph_pkg;

    localparam int unsigned SAMPLE_W = 8;
    localparam int unsigned ACC_W    = SAMPLE_W + 1;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [ACC_W-1:0]    acc_t;

    // Write request as captured by the first edge-detect stage.
    typedef struct packed {
        logic    hit;
        sample_t data;
    } wr_stage_t;

    function automatic sample_t status_byte(input logic ready);
        return {{(SAMPLE_W-1){1'b0}}, ready};
    endfunction

    // One modulator step: add the sample to the low bits of the accumulator.
    function automatic acc_t dsm_step(input acc_t acc, input sample_t s);
        return {1'b0, acc[SAMPLE_W-1:0]} + {1'b0, s};
    endfunction

endpackage

// File: rtl/dac_wr_edge.sv
module dac_wr_edge
    import dac_periph_pkg::*;
#(
    parameter int unsigned              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]        BASE_ADDR = 8'hE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  sample_t           wdata,
    output logic              start,
    output sample_t           start_data
);

    wr_stage_t stg1_q;
    logic      hit2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg1_q <= '0;
            hit2_q <= 1'b0;
        end else begin
            stg1_q.hit  <= we && (addr == BASE_ADDR);
            stg1_q.data <= wdata;
            hit2_q      <= stg1_q.hit;
        end
    end

    assign start      = stg1_q.hit & ~hit2_q;
    assign start_data = stg1_q.data;

endmodule

// File: rtl/dac_busy_timer.sv
module dac_busy_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic [CNT_W-1:0] cnt,
    output logic             full,
    output logic             done
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    assign full = &cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_MAX;
            run_q <= 1'b0;
        end else begin
            run_q <= ~full;
            if (start) begin
                cnt_q <= '0;
            end else if (!full) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt  = cnt_q;
    assign done = full & run_q;

endmodule

// File: rtl/dac_dsm.sv
module dac_dsm
    import dac_periph_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  sample_t load_data,
    output sample_t sample,
    output logic    dout
);

    sample_t sample_q;
    acc_t    acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0;
            acc_q    <= '0;
        end else begin
            if (load) begin
                sample_q <= load_data;
            end
            acc_q <= dsm_step(acc_q, sample_q);
        end
    end

    assign sample = sample_q;
    assign dout   = acc_q[ACC_W-1];

endmodule

// File: rtl/dac_periph.sv
module dac_periph
    import dac_periph_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_we,
    input  logic              io_re,
    output logic [7:0]        io_rdata,
    output logic              bus_ack,
    output logic              done_pulse,
    output logic              dac_out
);

    localparam logic [ADDR_W-1:0] STAT_ADDR = BASE_ADDR + ADDR_W'(1);

    logic             start_pulse;
    sample_t          start_data;
    logic [SAMPLE_W-1:0] busy_cnt;
    logic             timer_full;
    sample_t          cur_sample;

    dac_wr_edge #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (io_we),
        .addr      (io_addr),
        .wdata     (io_wdata),
        .start     (start_pulse),
        .start_data(start_data)
    );

    dac_busy_timer #(
        .CNT_W(SAMPLE_W)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start_pulse),
        .cnt  (busy_cnt),
        .full (timer_full),
        .done (done_pulse)
    );

    dac_dsm u_dsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_pulse),
        .load_data(start_data),
        .sample   (cur_sample),
        .dout     (dac_out)
    );

    assign bus_ack  = timer_full;
    assign io_rdata = (io_re && io_addr == STAT_ADDR) ? status_byte(timer_full) : '0;

endmodule

// File: rtl/dac_periph_chk.sv
module dac_periph_chk #(
    parameter int unsigned       ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hE0,
    parameter int unsigned       CNT_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_re,
    input logic [7:0]        io_rdata,
    input logic              bus_ack,
    input logic              done_pulse,
    input logic              start,
    input logic [CNT_W-1:0]  cnt,
    input logic [7:0]        sample
);

    localparam logic [ADDR_W-1:0] STAT_ADDR = BASE_ADDR + ADDR_W'(1);

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_re || io_addr != STAT_ADDR) |-> io_rdata == 8'h00);              // R3

    AST_STATUS_MATCH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (io_re && io_addr == STAT_ADDR) |-> io_rdata == {7'b0, bus_ack});      // R2

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);                                                     // R4

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> cnt == '0);                                                  // R5

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !bus_ack) |=> cnt == $past(cnt) + 1'b1);                    // R5

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && bus_ack) |=> bus_ack);                                      // R5

    AST_ACK_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack == (cnt == '1));                                               // R6

    AST_DONE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> bus_ack);                                               // R7

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);                                           // R7

    AST_SAMPLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(sample));                                           // R8

endmodule

bind dac_periph dac_periph_chk #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .CNT_W    (8)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_re     (io_re),
    .io_rdata  (io_rdata),
    .bus_ack   (bus_ack),
    .done_pulse(done_pulse),
    .start     (start_pulse),
    .cnt       (busy_cnt),
    .sample    (cur_sample)
);

// File: tb/dac_periph_bench.sv
`timescale 1ns/1ps
module dac_periph_bench;

    localparam logic [7:0] BASE = 8'hE0;
    localparam logic [7:0] STAT = BASE + 8'd1;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] io_addr;
    logic [7:0] io_wdata;
    logic       io_we;
    logic       io_re;
    logic [7:0] io_rdata;
    logic       bus_ack;
    logic       done_pulse;
    logic       dac_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dac_periph u_dac_periph (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .io_we     (io_we),
        .io_re     (io_re),
        .io_rdata  (io_rdata),
        .bus_ack   (bus_ack),
        .done_pulse(done_pulse),
        .dac_out   (dac_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected acknowledge k negedges after the strobe was first driven.
    function automatic bit exp_ack_at(input int k, input bit prior, input bit hit);
        if (!hit || k == 1) return prior;
        return k >= 257;
    endfunction

    task automatic write_watch(input logic [7:0] a, input logic [7:0] d,
                               input int len, input int ncyc, input bit prior,
                               input string req);
        bit hit;
        hit = (a == BASE);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_we = 1'b1; io_re = 1'b0;
        for (int k = 1; k <= ncyc; k++) begin
            bit ea;
            @(negedge clk);
            ea = exp_ack_at(k, prior, hit);
            check(bus_ack == ea, req, bus_ack, ea);
            check(done_pulse == (hit && k == 257), {req, " R7 done"}, done_pulse, hit && k == 257);
            if (io_we) check(io_rdata == 8'h00, "R3", io_rdata, 0);
            else       check(io_rdata == {7'b0, ea}, "R2", io_rdata, ea);
            if (k == len) begin
                io_we = 1'b0; io_addr = STAT; io_re = 1'b1;
            end
        end
    endtask

    task automatic count_ones(input int exp, input string req);
        int ones = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            ones += dac_out;
        end
        check(ones == exp, req, ones, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int         len;
        void'($urandom(32'd2024));
        rst_n = 1'b0; io_addr = STAT; io_wdata = 8'h00; io_we = 1'b0; io_re = 1'b1;
        repeat (4) @(negedge clk);
        check(bus_ack == 1'b1, "R10 ack", bus_ack, 1);
        check(done_pulse == 1'b0, "R10 done", done_pulse, 0);
        check(dac_out == 1'b0, "R10 dac_out", dac_out, 0);
        check(io_rdata == 8'h01, "R10 R2 status", io_rdata, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(io_rdata == 8'h01, "R2 ready", io_rdata, 1);
        io_addr = BASE;
        @(negedge clk);
        check(io_rdata == 8'h00, "R3 wrong addr", io_rdata, 0);
        io_addr = STAT; io_re = 1'b0;
        @(negedge clk);
        check(io_rdata == 8'h00, "R3 no re", io_rdata, 0);
        check(bus_ack == 1'b1, "R3 read no effect", bus_ack, 1);
        count_ones(0, "R9 R10 zero sample");

        write_watch(BASE, 8'h00, 1, 258, 1'b1, "R7 w00");
        count_ones(0, "R9 sample 0");
        write_watch(BASE, 8'hFF, 2, 258, 1'b1, "R7 wFF");
        count_ones(255, "R9 sample 255");
        write_watch(BASE, 8'h5A, 300, 300, 1'b1, "R4 long strobe");
        count_ones(8'h5A, "R9 R4 sample 5A");

        write_watch(BASE + 8'd2, 8'h33, 3, 260, 1'b1, "R1 other addr");
        count_ones(8'h5A, "R1 R8 sample kept");

        write_watch(BASE, 8'h11, 3, 100, 1'b1, "R11 first");
        write_watch(BASE, 8'hC3, 4, 258, 1'b0, "R11 restart");
        count_ones(8'hC3, "R11 R9 new sample");

        for (int n = 0; n < 5; n++) begin
            d   = 8'($urandom);
            len = 1 + int'($urandom % 8);
            write_watch(BASE, d, len, 258, 1'b1, "R5 R6 random");
            count_ones(d, "R9 random sample");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule